// File: doc/BRIEF.md
# Per-Pixel Palette / True-Colour Source Selector

This block sits in a display scanout path. For every pixel it receives three words that a memory fetch engine has already read: an 8-bit colour index, a 32-bit true-colour word and a 32-bit control word. It emits one registered 24-bit RGB pixel with a valid flag. The control word's tag byte picks the source pixel by pixel, so direct-colour regions and palette-mapped regions can share one frame.

The palette is a 256-entry, 24-bit RAM. It has its own write port, and software-side logic can rewrite it while scanout runs. A global index-only input models the 8-bit depth configuration. In that configuration the control and true-colour words are ignored and every pixel goes through the palette. Both sources pass through two register stages, so the source select and the colour data reach the output multiplexer together.

Top module: `pixsel_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `pix_valid_o` and `pix_rgb_o` are zero.
- R2: The plane words arrive on the bus with their lowest-address byte in bits 7:0. Each word is big-endian in memory, so its most significant byte is the lowest-address byte. When `idx_only_i` is low and `ctrl_i[7:0]` equals 8'h03, the output pixel is the true-colour word with red = `direct_i[15:8]`, green = `direct_i[23:16]` and blue = `direct_i[31:24]`. `direct_i[7:0]` is unused.
- R3: When `ctrl_i[7:0]` holds any value other than 8'h03, the output is the palette entry addressed by `idx_i`. The upper three bytes of `ctrl_i` have no effect on the choice.
- R4: When `idx_only_i` is high, every valid pixel is taken from the palette, even if `ctrl_i[7:0]` is 8'h03.
- R5: `pix_valid_o` equals `pix_valid_i` delayed by exactly two clock cycles. The pixel data is aligned with it.
- R6: When `pix_valid_o` is low, `pix_rgb_o` is zero.
- R7: A palette write to the entry that a pixel reads on the same clock edge does not affect that pixel, which gets the old value. Pixels presented on later cycles see the new value.
- R8: Palette entries store the 24-bit write data as written, with red in bits 23:16, green in 15:8 and blue in 7:0, and the output uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_only_i | input | 1 | Global index-only (8-bit depth) configuration |
| pix_valid_i | input | 1 | Pixel strobe for the three plane words |
| idx_i | input | 8 | Indexed-plane value |
| direct_i | input | 32 | True-colour plane word, memory byte order |
| ctrl_i | input | 32 | Control plane word, memory byte order |
| pal_we_i | input | 1 | Palette write enable |
| pal_waddr_i | input | 8 | Palette write address |
| pal_wdata_i | input | 24 | Palette write data {R,G,B} |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Output pixel {R,G,B} |

## Verification
The hardest case to reach is a palette write that lands on the same edge as a pixel read of that same entry. It comes from a narrow alignment of two independent ports. The stimulus forces it directly: it presents index 5 while writing entry 5, then presents index 5 again. Random traffic then adds more collisions by drawing write addresses and pixel indices from a small shared range. Tag bytes are also drawn so that 8'h03 appears often, both in the decisive byte and in the ignored bytes, and the index-only setting is toggled mid-stream.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

    localparam int WORD_W   = 32;
    localparam int CHAN_W   = 8;
    localparam int RGB_W    = 3 * CHAN_W;
    localparam int IDX_W    = 8;
    localparam int PAL_N    = 1 << IDX_W;
    localparam int LANES    = WORD_W / CHAN_W;
    localparam logic [CHAN_W-1:0] DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic use_direct;
        rgb_t direct;
    } stage1_t;

    function automatic rgb_t word_to_rgb(input logic [WORD_W-1:0] be_val);
        rgb_t c;
        c.r = be_val[23:16];
        c.g = be_val[15:8];
        c.b = be_val[7:0];
        return c;
    endfunction

endpackage

// File: rtl/pixsel_decode.sv
module pixsel_decode
    import pixsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              idx_only_i,
    input  logic [WORD_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] direct_i,
    output stage1_t           s1_o
);
    logic [WORD_W-1:0] ctrl_be;
    logic [WORD_W-1:0] direct_be;

    // memory byte order -> numeric big-endian value
    for (genvar ln = 0; ln < LANES; ln++) begin : g_swap
        assign ctrl_be[ln*CHAN_W +: CHAN_W]   = ctrl_i[(LANES-1-ln)*CHAN_W +: CHAN_W];
        assign direct_be[ln*CHAN_W +: CHAN_W] = direct_i[(LANES-1-ln)*CHAN_W +: CHAN_W];
    end

    stage1_t nxt;
    always_comb begin
        nxt.valid      = valid_i;
        nxt.use_direct = !idx_only_i && (ctrl_be[WORD_W-1 -: CHAN_W] == DIRECT_TAG);
        nxt.direct     = word_to_rgb(direct_be);
    end

    always_ff @(posedge clk) begin
        if (rst) s1_o <= '0;
        else     s1_o <= nxt;
    end
endmodule

// File: rtl/pixsel_palette.sv
module pixsel_palette
    import pixsel_pkg::*;
(
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  rgb_t             wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output rgb_t             rdata_o
);
    rgb_t mem [PAL_N];

    // read-before-write on a shared address
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/pixsel_out.sv
module pixsel_out
    import pixsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stage1_t s1_i,
    input  rgb_t    pal_i,
    output logic    valid_o,
    output rgb_t    rgb_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            rgb_o   <= '0;
        end else begin
            valid_o <= s1_i.valid;
            if (!s1_i.valid)         rgb_o <= '0;
            else if (s1_i.use_direct) rgb_o <= s1_i.direct;
            else                      rgb_o <= pal_i;
        end
    end
endmodule

// File: rtl/pixsel_top.sv
module pixsel_top
    import pixsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                idx_only_i,
    input  logic                pix_valid_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [WORD_W-1:0]   direct_i,
    input  logic [WORD_W-1:0]   ctrl_i,
    input  logic                pal_we_i,
    input  logic [IDX_W-1:0]    pal_waddr_i,
    input  logic [RGB_W-1:0]    pal_wdata_i,
    output logic                pix_valid_o,
    output logic [RGB_W-1:0]    pix_rgb_o
);
    stage1_t s1;
    rgb_t    pal_rd;
    rgb_t    rgb_q;

    pixsel_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (pix_valid_i),
        .idx_only_i (idx_only_i),
        .ctrl_i     (ctrl_i),
        .direct_i   (direct_i),
        .s1_o       (s1)
    );

    pixsel_palette u_pal (
        .clk     (clk),
        .we_i    (pal_we_i),
        .waddr_i (pal_waddr_i),
        .wdata_i (rgb_t'(pal_wdata_i)),
        .raddr_i (idx_i),
        .rdata_o (pal_rd)
    );

    pixsel_out u_out (
        .clk     (clk),
        .rst     (rst),
        .s1_i    (s1),
        .pal_i   (pal_rd),
        .valid_o (pix_valid_o),
        .rgb_o   (rgb_q)
    );

    assign pix_rgb_o = rgb_q;
endmodule

// File: rtl/pixsel_chk.sv
module pixsel_chk
    import pixsel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              idx_only_i,
    input logic              pix_valid_i,
    input logic [WORD_W-1:0] direct_i,
    input logic [WORD_W-1:0] ctrl_i,
    input logic              pix_valid_o,
    input logic [RGB_W-1:0]  pix_rgb_o
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (pix_valid_o == 1'b0 && pix_rgb_o == '0));

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2)));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_o |-> (pix_rgb_o == '0));

    // R2
    direct_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(pix_valid_i, 2) && !$past(idx_only_i, 2)
         && $past(ctrl_i[7:0], 2) == DIRECT_TAG)
        |-> (pix_rgb_o == {$past(direct_i[15:8], 2), $past(direct_i[23:16], 2),
                           $past(direct_i[31:24], 2)}));
endmodule

bind pixsel_top pixsel_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .idx_only_i  (idx_only_i),
    .pix_valid_i (pix_valid_i),
    .direct_i    (direct_i),
    .ctrl_i      (ctrl_i),
    .pix_valid_o (pix_valid_o),
    .pix_rgb_o   (pix_rgb_o)
);

// File: tb/tb_pixsel_top.sv
module tb_pixsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        idx_only_i;
    logic        pix_valid_i;
    logic [7:0]  idx_i;
    logic [31:0] direct_i;
    logic [31:0] ctrl_i;
    logic        pal_we_i;
    logic [7:0]  pal_waddr_i;
    logic [23:0] pal_wdata_i;
    logic        pix_valid_o;
    logic [23:0] pix_rgb_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixsel_top dut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    logic [23:0] ref_pal [256];
    logic        e1_v, e2_v;
    logic [23:0] e1_rgb, e2_rgb;
    string       e1_tag, e2_tag;
    logic        prev_we;
    logic [7:0]  prev_waddr;

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic io, input logic v, input logic [7:0] ix,
                        input logic [31:0] dw, input logic [31:0] cw,
                        input logic we, input logic [7:0] wa, input logic [23:0] wd);
        logic        nv;
        logic [23:0] nrgb;
        string       ntag;
        @(negedge clk);
        check((e2_tag == "R1") ? "R1" : "R5", {23'd0, pix_valid_o}, {23'd0, e2_v});
        check(e2_tag, pix_rgb_o, e2_rgb);
        e2_v = e1_v; e2_rgb = e1_rgb; e2_tag = e1_tag;
        nv = v; nrgb = 24'h0; ntag = "R6";
        if (r) begin
            nv = 0; ntag = "R1";
            e2_v = 0; e2_rgb = 24'h0; e2_tag = "R1";
        end else if (v) begin
            if (!io && cw[7:0] == 8'h03) begin
                nrgb = {dw[15:8], dw[23:16], dw[31:24]}; ntag = "R2";
            end else begin
                nrgb = ref_pal[ix];
                ntag = (io && cw[7:0] == 8'h03) ? "R4" : "R3";
                if (we && wa == ix) ntag = "R7";
                else if (prev_we && prev_waddr == ix) ntag = "R8";
            end
        end
        e1_v = nv; e1_rgb = nrgb; e1_tag = ntag;
        if (we) ref_pal[wa] = wd;
        prev_we = we; prev_waddr = wa;
        rst = r; idx_only_i = io; pix_valid_i = v; idx_i = ix;
        direct_i = dw; ctrl_i = cw; pal_we_i = we; pal_waddr_i = wa; pal_wdata_i = wd;
    endtask

    task automatic pix(input logic io, input logic [7:0] ix, input logic [31:0] dw, input logic [31:0] cw);
        step(0, io, 1, ix, dw, cw, 0, 8'h00, 24'h0);
    endtask

    initial begin
        e1_v = 0; e2_v = 0; e1_rgb = 0; e2_rgb = 0; e1_tag = "R1"; e2_tag = "R1";
        prev_we = 0; prev_waddr = 0;
        rst = 1; idx_only_i = 0; pix_valid_i = 0; idx_i = 0; direct_i = 0; ctrl_i = 0;
        pal_we_i = 0; pal_waddr_i = 0; pal_wdata_i = 0;
        // R1: reset with busy inputs
        for (int i = 0; i < 4; i++)
            step(1, 0, 1, 8'h11, 32'hAABBCCDD, 32'h00000003, 0, 0, 0);
        // R8: fill palette
        for (int i = 0; i < 256; i++)
            step(0, 0, 0, 8'h0, 32'hFFFFFFFF, 32'h03, 1, i[7:0],
                 {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A});
        // R2: direct tag
        pix(0, 8'h10, 32'h33221100, 32'h00000003);
        pix(0, 8'h10, 32'h0FF0A5C3, 32'hFFFFFF03);
        // R3: other tags, 0x03 in ignored bytes
        pix(0, 8'h20, 32'h33221100, 32'h00000002);
        pix(0, 8'h21, 32'h33221100, 32'h03030300);
        pix(0, 8'hFF, 32'h33221100, 32'h00000083);
        // R4: index-only mode
        pix(1, 8'h30, 32'h33221100, 32'h00000003);
        pix(1, 8'h00, 32'h33221100, 32'h00000000);
        // R6: invalid pixels with garbage
        step(0, 0, 0, 8'h44, 32'h12345678, 32'h03, 0, 0, 0);
        step(0, 1, 0, 8'h45, 32'h12345678, 32'h00, 0, 0, 0);
        // R7: same-edge write then re-read
        step(0, 0, 1, 8'h05, 32'h0, 32'h0, 1, 8'h05, 24'hC0FFEE);
        pix(0, 8'h05, 32'h0, 32'h0);
        pix(0, 8'h05, 32'h0, 32'h0);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] c;
            c = $urandom;
            if ($urandom_range(0, 2) == 0) c[7:0] = 8'h03;
            step(0, ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) != 0),
                 8'($urandom_range(0, 7)), $urandom, c,
                 $urandom_range(0, 1), 8'($urandom_range(0, 7)), 24'($urandom));
        end
        // R1: reset mid-stream then resume
        for (int i = 0; i < 3; i++)
            step(1, 0, 1, 8'h01, 32'h0, 32'h03, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            pix(0, 8'($urandom_range(0, 255)), $urandom, 32'h03);
        for (int i = 0; i < 3; i++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule